// File: doc/BRIEF.md
# Conditional Data-Processing Execute Unit

This block executes one already-fetched 32-bit data-processing instruction word. It takes the first source operand, a second operand that an external shifter has already prepared (register or rotated immediate), and that shifter's carry-out. It checks the 4-bit condition field against the current N, Z, C and V flags and runs one of sixteen ALU operations. It then reports the result, whether the destination register is written, which register that is, whether the flags are updated, and the next flag value.

Words outside the data-processing class produce no register or flag write. Multiply words are reported on their own output and are not executed. All outputs come from a single register stage, so they appear one clock after the inputs are presented.

Top module: `dpx_unit`

## Requirements
- R1: The condition field instr[31:28] passes as follows (value: test): 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V), 14 always. Flags are packed as {N,Z,C,V} in bits 3..0 of flags_in and flags_out.
- R2: When the condition fails, or the field is 15 (never), rd_we and flags_we are both 0 and flags_out equals flags_in.
- R3: result carries the operation picked by instr[24:21]: 0 Rn&Op2, 1 Rn^Op2, 2 Rn-Op2, 3 Op2-Rn, 4 Rn+Op2, 5 Rn+Op2+C, 6 Rn-Op2-!C, 7 Op2-Rn-!C, 8 Rn&Op2, 9 Rn^Op2, 10 Rn-Op2, 11 Rn+Op2, 12 Rn|Op2, 13 Op2, 14 Rn&~Op2, 15 ~Op2. This holds whether or not the result is written.
- R4: For arithmetic opcodes (2 to 7, 10, 11), the new C is the adder carry-out, which is 1 when no borrow occurs in a subtraction, and the new V is the signed overflow.
- R5: For logical opcodes (0, 1, 8, 9, 12 to 15), the new C equals op2_carry and the new V equals the incoming V.
- R6: The new N is result bit 31 and the new Z is 1 exactly when the result is zero.
- R7: flags_we is 1 only when instr[20] is set and the instruction executes; otherwise flags_out equals flags_in.
- R8: Compare opcodes 8 to 11 never write Rd. Other executing opcodes set rd_we, and rd_idx is instr[15:12].
- R9: Opcodes 13 and 15 give a result that does not depend on rn_val.
- R10: status_upd is 1 when an executing compare opcode with instr[20] set has instr[15:12] equal to 15.
- R11: A word with instr[27:22] all zero and instr[7] and instr[4] both set raises mul_word and writes nothing. A word with instr[27:26] not 00 writes nothing.
- R12: All outputs are zero during reset. Outputs reflect the inputs one clock later, and out_valid follows in_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word present this cycle |
| instr | input | 32 | Instruction word |
| rn_val | input | DATA_W | First source operand value |
| op2_val | input | DATA_W | Second operand from the shifter |
| op2_carry | input | 1 | Shifter carry-out |
| flags_in | input | 4 | Current {N,Z,C,V} |
| out_valid | output | 1 | Registered in_valid |
| result | output | DATA_W | ALU result |
| rd_we | output | 1 | Destination register write enable |
| rd_idx | output | 4 | Destination register index |
| flags_we | output | 1 | Flag update enable |
| flags_out | output | 4 | Next {N,Z,C,V} |
| status_upd | output | 1 | Compare form that also updates status bits |
| mul_word | output | 1 | Word is a multiply and was not executed |

## Verification
The block keeps no state across instructions apart from its single output register. A fault in condition or opcode decoding therefore shows up on the very next cycle: a write enable that is wrong, a flag vector that has moved when it should have held, or a result belonging to the wrong operation. Random words are checked against a model that computes carry and overflow from wide signed and unsigned sums rather than from an adder carry chain. This lets a mistake in carry polarity or overflow show in the first few hundred words. Directed words cover the never condition, multiply patterns and near-misses, compare writes, and independence from Rn.

// File: rtl/dpx_pkg.sv
package dpx_pkg;
   localparam int FL_N = 3;
   localparam int FL_Z = 2;
   localparam int FL_C = 1;
   localparam int FL_V = 0;

   typedef enum logic [3:0] {
      OP_AND = 4'd0, OP_EOR = 4'd1, OP_SUB = 4'd2, OP_RSB = 4'd3,
      OP_ADD = 4'd4, OP_ADC = 4'd5, OP_SBC = 4'd6, OP_RSC = 4'd7,
      OP_TST = 4'd8, OP_TEQ = 4'd9, OP_CMP = 4'd10, OP_CMN = 4'd11,
      OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
   } alu_op_e;

   typedef enum logic [3:0] {
      CC_EQ = 4'd0, CC_NE = 4'd1, CC_CS = 4'd2, CC_CC = 4'd3,
      CC_MI = 4'd4, CC_PL = 4'd5, CC_VS = 4'd6, CC_VC = 4'd7,
      CC_HI = 4'd8, CC_LS = 4'd9, CC_GE = 4'd10, CC_LT = 4'd11,
      CC_GT = 4'd12, CC_LE = 4'd13, CC_AL = 4'd14, CC_NV = 4'd15
   } cond_e;

   function automatic logic is_test(input alu_op_e op);
      return op[3:2] == 2'b10;
   endfunction
endpackage

// File: rtl/dpx_cond.sv
module dpx_cond
   import dpx_pkg::*;
(
   input  logic [3:0] cond_i,
   input  logic [3:0] flags_i,
   output logic       pass_o
);
   logic n, z, c, v;
   assign n = flags_i[FL_N];
   assign z = flags_i[FL_Z];
   assign c = flags_i[FL_C];
   assign v = flags_i[FL_V];

   always_comb begin
      unique case (cond_e'(cond_i))
         CC_EQ: pass_o = z;
         CC_NE: pass_o = !z;
         CC_CS: pass_o = c;
         CC_CC: pass_o = !c;
         CC_MI: pass_o = n;
         CC_PL: pass_o = !n;
         CC_VS: pass_o = v;
         CC_VC: pass_o = !v;
         CC_HI: pass_o = c && !z;
         CC_LS: pass_o = !c || z;
         CC_GE: pass_o = (n == v);
         CC_LT: pass_o = (n != v);
         CC_GT: pass_o = !z && (n == v);
         CC_LE: pass_o = z || (n != v);
         CC_AL: pass_o = 1'b1;
         default: pass_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/dpx_alu.sv
module dpx_alu
   import dpx_pkg::*;
#(
   parameter int W = 32
) (
   input  alu_op_e        op_i,
   input  logic [W-1:0]   a_i,
   input  logic [W-1:0]   b_i,
   input  logic           c_i,
   input  logic           shc_i,
   input  logic           v_i,
   output logic [W-1:0]   res_o,
   output logic [3:0]     flags_o
);
   logic           arith;
   logic           cin;
   logic [W-1:0]   x, y, lres;
   logic [W:0]     sum;
   logic           ovf;

   // adder operand steering: subtraction is x + ~y + carry
   always_comb begin
      arith = 1'b1;
      x     = a_i;
      y     = b_i;
      cin   = 1'b0;
      unique case (op_i)
         OP_SUB, OP_CMP: begin y = ~b_i; cin = 1'b1; end
         OP_RSB:         begin x = b_i; y = ~a_i; cin = 1'b1; end
         OP_ADD, OP_CMN: begin end
         OP_ADC:         cin = c_i;
         OP_SBC:         begin y = ~b_i; cin = c_i; end
         OP_RSC:         begin x = b_i; y = ~a_i; cin = c_i; end
         default:        arith = 1'b0;
      endcase
   end

   assign sum = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
   assign ovf = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);

   always_comb begin
      unique case (op_i)
         OP_AND, OP_TST: lres = a_i & b_i;
         OP_EOR, OP_TEQ: lres = a_i ^ b_i;
         OP_ORR:         lres = a_i | b_i;
         OP_MOV:         lres = b_i;
         OP_BIC:         lres = a_i & ~b_i;
         OP_MVN:         lres = ~b_i;
         default:        lres = '0;
      endcase
   end

   assign res_o = arith ? sum[W-1:0] : lres;

   always_comb begin
      flags_o[FL_N] = res_o[W-1];
      flags_o[FL_Z] = (res_o == '0);
      flags_o[FL_C] = arith ? sum[W] : shc_i;
      flags_o[FL_V] = arith ? ovf : v_i;
   end
endmodule

// File: rtl/dpx_stage.sv
module dpx_stage #(
   parameter int  PW      = 8,
   parameter bit  OUT_REG = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [PW-1:0] d_i,
   output logic [PW-1:0] q_o
);
   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) q_o <= '0;
         else        q_o <= d_i;
      end
   end else begin : g_wire
      assign q_o = d_i;
   end
endmodule

// File: rtl/dpx_unit.sv
module dpx_unit
   import dpx_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [31:0]       instr,
   input  logic [DATA_W-1:0] rn_val,
   input  logic [DATA_W-1:0] op2_val,
   input  logic              op2_carry,
   input  logic [3:0]        flags_in,
   output logic              out_valid,
   output logic [DATA_W-1:0] result,
   output logic              rd_we,
   output logic [3:0]        rd_idx,
   output logic              flags_we,
   output logic [3:0]        flags_out,
   output logic              status_upd,
   output logic              mul_word
);
   localparam int PW = DATA_W + 13;

   if (DATA_W < 8) begin : g_bad_width
      $error("dpx_unit: DATA_W must be at least 8");
   end

   alu_op_e           op;
   logic              cls_ok, mul_hit, pass, exec, test_op;
   logic              wr, fwe, stat;
   logic [3:0]        alu_fl, nxt_fl;
   logic [DATA_W-1:0] alu_res;
   logic [PW-1:0]     st_d, st_q;

   assign op      = alu_op_e'(instr[24:21]);
   assign cls_ok  = (instr[27:26] == 2'b00);
   assign mul_hit = (instr[27:22] == 6'd0) && instr[7] && instr[4];

   dpx_cond u_cond (
      .cond_i  (instr[31:28]),
      .flags_i (flags_in),
      .pass_o  (pass)
   );

   dpx_alu #(.W(DATA_W)) u_alu (
      .op_i    (op),
      .a_i     (rn_val),
      .b_i     (op2_val),
      .c_i     (flags_in[FL_C]),
      .shc_i   (op2_carry),
      .v_i     (flags_in[FL_V]),
      .res_o   (alu_res),
      .flags_o (alu_fl)
   );

   assign exec    = in_valid && cls_ok && !mul_hit && pass;
   assign test_op = is_test(op);
   assign wr      = exec && !test_op;
   assign fwe     = exec && instr[20];
   assign stat    = fwe && test_op && (instr[15:12] == 4'hF);
   assign nxt_fl  = fwe ? alu_fl : flags_in;

   assign st_d = {in_valid, alu_res, wr, instr[15:12], fwe, nxt_fl, stat,
                  in_valid && mul_hit};

   dpx_stage #(.PW(PW), .OUT_REG(OUT_REG)) u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (st_d),
      .q_o   (st_q)
   );

   assign {out_valid, result, rd_we, rd_idx, flags_we, flags_out, status_upd,
           mul_word} = st_q;
endmodule

// File: rtl/dpx_chk.sv
module dpx_chk #(
   parameter int DATA_W  = 32,
   parameter bit OUT_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [31:0]       instr,
   input logic [3:0]        flags_in,
   input logic              out_valid,
   input logic [DATA_W-1:0] result,
   input logic              rd_we,
   input logic [3:0]        rd_idx,
   input logic              flags_we,
   input logic [3:0]        flags_out,
   input logic              status_upd,
   input logic              mul_word
);
   logic        p_valid;
   logic [31:0] p_instr;
   logic [3:0]  p_flags;

   // align the observed inputs with the outputs they produce
   if (OUT_REG) begin : g_dly
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            p_valid <= 1'b0;
            p_instr <= '0;
            p_flags <= '0;
         end else begin
            p_valid <= in_valid;
            p_instr <= instr;
            p_flags <= flags_in;
         end
      end
   end else begin : g_now
      assign p_valid = in_valid;
      assign p_instr = instr;
      assign p_flags = flags_in;
   end

   logic p_test, p_logic, p_mul;
   assign p_test  = (p_instr[24:23] == 2'b10);
   assign p_logic = !((p_instr[24:21] >= 4'd2 && p_instr[24:21] <= 4'd7) ||
                      p_instr[24:21] == 4'd10 || p_instr[24:21] == 4'd11);
   assign p_mul   = p_valid && (p_instr[27:22] == 6'd0) && p_instr[7] && p_instr[4];

   assert_never_cond_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (p_instr[31:28] == 4'hF) |-> (!rd_we && !flags_we && flags_out == p_flags));

   assert_hold_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !flags_we |-> (flags_out == p_flags));

   assert_sbit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      flags_we |-> (p_valid && p_instr[20]));

   assert_no_cmp_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_we |-> (p_valid && !p_test && rd_idx == p_instr[15:12]));

   assert_nz_R6: assert property (@(posedge clk) disable iff (!rst_n)
      flags_we |-> (flags_out[3] == result[DATA_W-1] &&
                    flags_out[2] == (result == '0)));

   assert_logic_v_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_we && p_logic) |-> (flags_out[0] == p_flags[0]));

   assert_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
      status_upd |-> (flags_we && p_test && p_instr[15:12] == 4'hF));

   assert_mul_R11: assert property (@(posedge clk) disable iff (!rst_n)
      p_mul |-> (mul_word && !rd_we && !flags_we));

   assert_class_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (p_instr[27:26] != 2'b00) |-> (!rd_we && !flags_we && !mul_word));

   assert_valid_R12: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == p_valid);
endmodule

bind dpx_unit dpx_chk #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .instr      (instr),
   .flags_in   (flags_in),
   .out_valid  (out_valid),
   .result     (result),
   .rd_we      (rd_we),
   .rd_idx     (rd_idx),
   .flags_we   (flags_we),
   .flags_out  (flags_out),
   .status_upd (status_upd),
   .mul_word   (mul_word)
);

// File: tb/tb_dpx_unit.sv
`timescale 1ns/1ps
module tb_dpx_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] instr = '0;
   logic [31:0] rn_val = '0;
   logic [31:0] op2_val = '0;
   logic        op2_carry = 1'b0;
   logic [3:0]  flags_in = '0;
   logic        out_valid, rd_we, flags_we, status_upd, mul_word;
   logic [31:0] result;
   logic [3:0]  rd_idx, flags_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   dpx_unit dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
      .rn_val(rn_val), .op2_val(op2_val), .op2_carry(op2_carry),
      .flags_in(flags_in), .out_valid(out_valid), .result(result),
      .rd_we(rd_we), .rd_idx(rd_idx), .flags_we(flags_we),
      .flags_out(flags_out), .status_upd(status_upd), .mul_word(mul_word)
   );

   function automatic bit cond_ok(input [3:0] cc, input [3:0] f);
      bit n = f[3], z = f[2], c = f[1], v = f[0];
      case (cc)
         4'd0: return z;           4'd1: return !z;
         4'd2: return c;           4'd3: return !c;
         4'd4: return n;           4'd5: return !n;
         4'd6: return v;           4'd7: return !v;
         4'd8: return c && !z;     4'd9: return !c || z;
         4'd10: return n == v;     4'd11: return n != v;
         4'd12: return !z && n == v;
         4'd13: return z || n != v;
         4'd14: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   // wide-integer reference for the ALU
   function automatic void ref_alu(input [3:0] op, input [31:0] a, input [31:0] b,
                                   input [3:0] f, input shc,
                                   output [31:0] r, output [3:0] nf);
      bit arith = 1'b1, sub = 1'b0, cin = 1'b0, cr, vr;
      logic [31:0] x = a, y = b;
      longint us, ss;
      r = '0;
      case (op)
         4'd2, 4'd10: begin sub = 1; cin = 1; end
         4'd3: begin sub = 1; cin = 1; x = b; y = a; end
         4'd4, 4'd11: cin = 0;
         4'd5: cin = f[1];
         4'd6: begin sub = 1; cin = f[1]; end
         4'd7: begin sub = 1; cin = f[1]; x = b; y = a; end
         default: arith = 1'b0;
      endcase
      if (arith) begin
         if (sub) begin
            us = longint'({32'h0, x}) - longint'({32'h0, y}) - (cin ? 64'sd0 : 64'sd1);
            ss = longint'($signed(x)) - longint'($signed(y)) - (cin ? 64'sd0 : 64'sd1);
            cr = (us >= 0);
         end else begin
            us = longint'({32'h0, x}) + longint'({32'h0, y}) + (cin ? 64'sd1 : 64'sd0);
            ss = longint'($signed(x)) + longint'($signed(y)) + (cin ? 64'sd1 : 64'sd0);
            cr = us[32];
         end
         r  = us[31:0];
         vr = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
         nf = {r[31], r == 32'h0, cr, vr};
      end else begin
         case (op)
            4'd0, 4'd8: r = a & b;
            4'd1, 4'd9: r = a ^ b;
            4'd12: r = a | b;
            4'd13: r = b;
            4'd14: r = a & ~b;
            default: r = ~b;
         endcase
         nf = {r[31], r == 32'h0, shc, f[0]};
      end
   endfunction

   task automatic expect_eq(input string tag, input string what,
                            input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // apply one word, wait one edge, compare every output against the model
   task automatic run_op(input string tag, input bit vld, input [31:0] w,
                         input [31:0] a, input [31:0] b, input bit shc,
                         input [3:0] f);
      logic [31:0] er;
      logic [3:0]  af, ef;
      bit cls, mul, ex, tst, ewe, efwe, est, emul;
      in_valid = vld; instr = w; rn_val = a; op2_val = b;
      op2_carry = shc; flags_in = f;
      ref_alu(w[24:21], a, b, f, shc, er, af);
      cls  = (w[27:26] == 2'b00);
      mul  = (w[27:22] == 6'd0) && w[7] && w[4];
      ex   = vld && cls && !mul && cond_ok(w[31:28], f);
      tst  = (w[24:23] == 2'b10);
      ewe  = ex && !tst;
      efwe = ex && w[20];
      est  = efwe && tst && (w[15:12] == 4'hF);
      emul = vld && mul;
      ef   = efwe ? af : f;
      @(negedge clk);
      expect_eq(tag, "result", {32'h0, result}, {32'h0, er});
      expect_eq(tag, "flags", {60'h0, flags_out}, {60'h0, ef});
      expect_eq(tag, "ctl",
                {57'h0, out_valid, rd_we, flags_we, status_upd, mul_word, rd_idx},
                {57'h0, vld, ewe, efwe, est, emul, w[15:12]});
   endtask

   function automatic logic [31:0] mk(input [3:0] cc, input [3:0] op, input bit s,
                                      input [3:0] rn, input [3:0] rd);
      return {cc, 2'b00, 1'b0, op, s, rn, rd, 12'h000};
   endfunction

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R12: reset state
      expect_eq("R12", "reset",
                {22'h0, out_valid, result, rd_we, rd_idx, flags_we, flags_out, status_upd, mul_word},
                64'h0);
      rst_n = 1'b1;

      // R3 R4: signed overflow on add, borrow on subtract, reverse subtract
      run_op("R4", 1, mk(4'hE, 4'd4, 1, 4'd1, 4'd2), 32'h7FFF_FFFF, 32'h1, 0, 4'h0);
      run_op("R4", 1, mk(4'hE, 4'd2, 1, 4'd1, 4'd2), 32'h0, 32'h1, 0, 4'h0);
      run_op("R3", 1, mk(4'hE, 4'd3, 1, 4'd1, 4'd2), 32'h5, 32'h3, 0, 4'h0);
      run_op("R4", 1, mk(4'hE, 4'd5, 1, 4'd1, 4'd2), 32'hFFFF_FFFF, 32'h0, 0, 4'h2);
      run_op("R4", 1, mk(4'hE, 4'd6, 1, 4'd1, 4'd2), 32'h8000_0000, 32'h0, 0, 4'h0);
      run_op("R4", 1, mk(4'hE, 4'd7, 1, 4'd1, 4'd2), 32'h1, 32'h1, 0, 4'h2);
      // R5: logical op carry from shifter, V held
      run_op("R5", 1, mk(4'hE, 4'd12, 1, 4'd3, 4'd4), 32'h0, 32'h0, 1, 4'h1);
      // R6: zero result on compare-negative
      run_op("R6", 1, mk(4'hE, 4'd11, 1, 4'd3, 4'd0), 32'hFFFF_FFFF, 32'h1, 0, 4'h0);
      // R9: MOV and MVN with two different Rn values
      run_op("R9", 1, mk(4'hE, 4'd13, 0, 4'd5, 4'd6), 32'h1234_5678, 32'hCAFE_0001, 0, 4'h0);
      run_op("R9", 1, mk(4'hE, 4'd13, 0, 4'd5, 4'd6), 32'h0, 32'hCAFE_0001, 0, 4'h0);
      run_op("R9", 1, mk(4'hE, 4'd15, 1, 4'd5, 4'd6), 32'hFFFF_0000, 32'h0F0F_0F0F, 0, 4'h0);
      // R8: compare never writes Rd; compare with S clear writes nothing
      run_op("R8", 1, mk(4'hE, 4'd10, 1, 4'd1, 4'd7), 32'h9, 32'h9, 0, 4'h0);
      run_op("R8", 1, mk(4'hE, 4'd8, 0, 4'd1, 4'd7), 32'h9, 32'h9, 0, 4'hF);
      // R10: compare with Rd field 15
      run_op("R10", 1, mk(4'hE, 4'd9, 1, 4'd1, 4'hF), 32'h9, 32'h6, 1, 4'h0);
      // R2: never condition and a failing EQ
      run_op("R2", 1, mk(4'hF, 4'd4, 1, 4'd1, 4'd2), 32'h1, 32'h1, 0, 4'hF);
      run_op("R2", 1, mk(4'h0, 4'd4, 1, 4'd1, 4'd2), 32'h1, 32'h1, 0, 4'h0);
      // R7: no S bit, flags pass through
      run_op("R7", 1, mk(4'hE, 4'd2, 0, 4'd1, 4'd2), 32'h0, 32'h1, 0, 4'hA);
      // R11: multiply words, a near-miss that executes, and a non-class word
      run_op("R11", 1, 32'hE000_0091, 32'h3, 32'h4, 0, 4'h0);
      run_op("R11", 1, 32'hE030_0091, 32'h3, 32'h4, 0, 4'h0);
      run_op("R11", 1, 32'hE081_0092, 32'h3, 32'h4, 0, 4'h0);
      run_op("R11", 1, 32'hE591_0000, 32'h3, 32'h4, 0, 4'h0);
      // R12: idle cycle, out_valid drops
      run_op("R12", 0, mk(4'hE, 4'd4, 1, 4'd1, 4'd2), 32'h1, 32'h1, 0, 4'h0);
      // R1: every condition against every flag pattern
      for (int cc = 0; cc < 16; cc++)
         for (int f = 0; f < 16; f++)
            run_op("R1", 1, mk(cc[3:0], 4'd4, 1, 4'd1, 4'd2), 32'h10, 32'h20, 0, f[3:0]);
      // R3: constrained random words
      for (int i = 0; i < 4000; i++) begin
         logic [31:0] w, a, b;
         w = $urandom;
         if ($urandom_range(0, 7) != 0) w[27:26] = 2'b00;
         if ($urandom_range(0, 3) == 0) w[31:28] = 4'hE;
         a = $urandom;
         b = $urandom;
         if ($urandom_range(0, 7) == 0) b = a;
         if ($urandom_range(0, 15) == 0) a = 32'h8000_0000;
         run_op("R3", ($urandom_range(0, 15) != 0), w, a, b,
                1'($urandom_range(0, 1)), 4'($urandom_range(0, 15)));
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule